// File: doc/BRIEF.md
# Maskable Interrupt Pin Controller

This block collects eight event sources into latched status bits and raises one shared interrupt pin. Each source has an enable bit that decides whether its latched status can assert the pin. A single programmable bit sets the level the pin drives when it is asserted. When the pin is not asserted it is not driven. The pin is modelled as a value output and an output-enable, and an external pull resistor fixes the idle level.

Management logic uses a small register port with two words. The interrupt word carries the enables in its upper byte and the latched status in its lower byte. The configuration word carries the polarity bit. Reading the interrupt word returns its current contents and clears all latched status in the same clock edge. An event that arrives on that edge is latched anyway, so no event is lost.

The event inputs are single-cycle pulses with no handshake. Every pulse is accepted in the cycle it appears, so the block never applies back-pressure. The register port is plain control: a read or a write completes in one cycle with no stall.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset, all status bits and all enable bits are 0, the polarity bit is 0 (active-low), and `pin_oe` is 0.
- R2: A 1 on `evt_i[i]` at a clock edge sets status bit i at that edge. The bit stays set until the interrupt word is read.
- R3: Status bits latch events whether or not the matching enable bit is set.
- R4: With `reg_sel`=0, `rd_data` = {enable[7:0], status[7:0]}. A cycle with `rd_en`=1 and `reg_sel`=0 clears every status bit at the next edge.
- R5: An event pulse in the same cycle as a clearing read leaves its status bit set after that edge.
- R6: A write with `reg_sel`=0 loads the enables from `wr_data[15:8]`. `wr_data[7:0]` is ignored, so status bits cannot be written.
- R7: `pin_oe` is 1 exactly when at least one status bit is set together with its enable bit.
- R8: While `pin_oe` is 1, `pin_o` equals the polarity bit: 1 means the pin is driven high when asserted, and 0 means it is driven low.
- R9: When no enabled status bit is set, `pin_oe` is 0 and the pin is left floating.
- R10: With `reg_sel`=1, `rd_data` = {15'b0, polarity}. A write with `reg_sel`=1 loads the polarity from `wr_data[0]`. Reading this word does not clear status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event pulses, one per source |
| reg_sel | input | 1 | Word select: 0 interrupt word, 1 configuration word |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected word (combinational) |
| pin_o | output | 1 | Level driven on the pin when enabled |
| pin_oe | output | 1 | Pin output enable; 0 leaves the pin floating |

## Verification
The hardest case to reach is an event pulse landing on the same edge as a clearing read. It needs exact cycle alignment between the event input and the read strobe. The stimulus table holds a vector that drives both in one cycle. That vector checks that the read returns only the older bits and that the new bit remains set and still holds the pin asserted. Another vector writes the enables in the same cycle a new event lands, to show the pin asserts right after that edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    SEL_IRQ_WORD = 1'b0,
    SEL_CFG_WORD = 1'b1
  } irq_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] status_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)            status_q[i] <= 1'b0;
      else if (evt_i[i])     status_q[i] <= 1'b1;  // new event wins over clear
      else if (clr_i)        status_q[i] <= 1'b0;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int NUM_SRC = 8,
  localparam int WordW = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic               sel_i,
  input  logic [WordW-1:0]   wr_data_i,
  output logic [NUM_SRC-1:0] enable_o,
  output logic               pol_hi_o
);
  import irq_pkg::*;

  logic [NUM_SRC-1:0] enable_q;
  logic               pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      pol_q    <= 1'b0;
    end else if (wr_en_i) begin
      if (irq_sel_e'(sel_i) == SEL_IRQ_WORD) enable_q <= wr_data_i[WordW-1:NUM_SRC];
      else                                    pol_q    <= wr_data_i[0];
    end
  end

  assign enable_o = enable_q;
  assign pol_hi_o = pol_q;
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic               pol_hi_i,
  output logic               pin_o,
  output logic               pin_oe_o
);
  logic [NUM_SRC-1:0] gated;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
    assign gated[i] = status_i[i] & enable_i[i];
  end

  assign pin_oe_o = |gated;
  assign pin_o    = pol_hi_i;
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl #(
  parameter int NUM_SRC = 8,
  localparam int WordW = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               reg_sel,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [WordW-1:0]   wr_data,
  output logic [WordW-1:0]   rd_data,
  output logic               pin_o,
  output logic               pin_oe
);
  import irq_pkg::*;

  logic [NUM_SRC-1:0] status_w;
  logic [NUM_SRC-1:0] enable_w;
  logic               pol_w;
  logic               clr_w;

  assign clr_w = rd_en && (irq_sel_e'(reg_sel) == SEL_IRQ_WORD);

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .clr_i    (clr_w),
    .status_o (status_w)
  );

  irq_ctrl_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .sel_i     (reg_sel),
    .wr_data_i (wr_data),
    .enable_o  (enable_w),
    .pol_hi_o  (pol_w)
  );

  irq_pin_drive #(.NUM_SRC(NUM_SRC)) u_pin (
    .status_i (status_w),
    .enable_i (enable_w),
    .pol_hi_i (pol_w),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe)
  );

  always_comb begin
    if (irq_sel_e'(reg_sel) == SEL_IRQ_WORD) rd_data = {enable_w, status_w};
    else                                      rd_data = {{(WordW-1){1'b0}}, pol_w};
  end
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk #(
  parameter int NUM_SRC = 8,
  localparam int WordW = 2 * NUM_SRC
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               reg_sel,
  input logic               rd_en,
  input logic               wr_en,
  input logic [WordW-1:0]   wr_data,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] enable,
  input logic               pol,
  input logic               pin_o,
  input logic               pin_oe
);
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status & $past(evt_i)) == $past(evt_i)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !reg_sel) |=> ((status & $past(status)) == $past(status)));

  p_clear_keeps_new_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !reg_sel) |=> (status == $past(evt_i)));

  p_enable_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> (enable == $past(wr_data[WordW-1:NUM_SRC])));

  p_pol_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel) |=> (pol == $past(wr_data[0])));

  p_assert_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) != '0) |-> (pin_oe && (pin_o == pol)));

  p_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) == '0) |-> !pin_oe);
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_i   (evt_i),
  .reg_sel (reg_sel),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .status  (status_w),
  .enable  (enable_w),
  .pol     (pol_w),
  .pin_o   (pin_o),
  .pin_oe  (pin_oe)
);

// File: tb/irq_pin_ctrl_tb.sv
module irq_pin_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [3:0]  req;
    logic        rd;
    logic        wr;
    logic        sel;
    logic [15:0] wdata;
    logic [7:0]  evt;
    logic [15:0] exp_rd;
    logic        exp_oe;
    logic        exp_o;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd3,  1'b0,1'b0,1'b0,16'h0000,8'h01,16'h0000,1'b0,1'b0}, // R3 latch while disabled
    '{4'd4,  1'b1,1'b0,1'b0,16'h0000,8'h00,16'h0001,1'b0,1'b0}, // R4 read returns + clears
    '{4'd6,  1'b0,1'b1,1'b0,16'h05FF,8'h00,16'h0000,1'b0,1'b0}, // R6 enables 0x05, low byte ignored
    '{4'd6,  1'b1,1'b0,1'b0,16'h0000,8'h00,16'h0500,1'b0,1'b0}, // R6 status still zero
    '{4'd7,  1'b0,1'b0,1'b0,16'h0000,8'h02,16'h0000,1'b0,1'b0}, // R7 masked source
    '{4'd8,  1'b0,1'b0,1'b0,16'h0000,8'h04,16'h0000,1'b1,1'b0}, // R8 active-low assert
    '{4'd8,  1'b0,1'b1,1'b1,16'h0001,8'h00,16'h0000,1'b1,1'b1}, // R8 switch to active-high
    '{4'd10, 1'b1,1'b0,1'b1,16'h0000,8'h00,16'h0001,1'b1,1'b1}, // R10 cfg read, no clear
    '{4'd5,  1'b1,1'b0,1'b0,16'h0000,8'h01,16'h0506,1'b1,1'b1}, // R5 event during clear
    '{4'd9,  1'b1,1'b0,1'b0,16'h0000,8'h00,16'h0501,1'b0,1'b0}, // R9 floats after clear
    '{4'd10, 1'b0,1'b1,1'b1,16'hFFFE,8'h00,16'h0000,1'b0,1'b0}, // R10 only bit0 used
    '{4'd10, 1'b1,1'b0,1'b1,16'h0000,8'h00,16'h0000,1'b0,1'b0}, // R10 reads zero word
    '{4'd7,  1'b0,1'b1,1'b0,16'h8000,8'h80,16'h0000,1'b1,1'b0}, // R7 enable+event same cycle
    '{4'd4,  1'b1,1'b0,1'b0,16'h0000,8'h00,16'h8080,1'b0,1'b0}  // R4 clear drops pin
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  evt_i;
  logic        reg_sel, rd_en, wr_en;
  logic [15:0] wr_data, rd_data;
  logic        pin_o, pin_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pin_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_sel(reg_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_i = '0; rd_en = 1'b0; wr_en = 1'b0; reg_sel = 1'b0; wr_data = '0;
  endtask

  task automatic check_reset_state();
    idle();
    #1;
    check("R1 pin_oe", {15'b0, pin_oe}, 16'h0000);
    check("R1 irq word", rd_data, 16'h0000);
    reg_sel = 1'b1;
    #1;
    check("R1 cfg word", rd_data, 16'h0000);
    reg_sel = 1'b0;
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rd_en = VECS[v].rd; wr_en = VECS[v].wr; reg_sel = VECS[v].sel;
      wr_data = VECS[v].wdata; evt_i = VECS[v].evt;
      #1;
      if (VECS[v].rd)
        check($sformatf("R%0d rd_data vec %0d", VECS[v].req, v), rd_data, VECS[v].exp_rd);
      @(posedge clk);
      @(negedge clk);
      idle();
      check($sformatf("R%0d pin_oe vec %0d", VECS[v].req, v), {15'b0, pin_oe}, {15'b0, VECS[v].exp_oe});
      if (VECS[v].exp_oe)
        check($sformatf("R%0d pin_o vec %0d", VECS[v].req, v), {15'b0, pin_o}, {15'b0, VECS[v].exp_o});
    end

    // R2: event stays latched across idle cycles until read
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h1000;
    @(negedge clk); idle(); evt_i = 8'h10;
    @(negedge clk); idle();
    repeat (4) @(negedge clk);
    check("R2 held pin", {15'b0, pin_oe}, 16'h0001);
    #1;
    check("R2 held status", rd_data, 16'h1010);

    // R1: reset in mid-run clears everything
    @(negedge clk); wr_en = 1'b1; reg_sel = 1'b1; wr_data = 16'h0001;
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_reset_state();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule